// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock synchronous static memory with registered inputs and a registered read output. The address, write data, the three chip enables, both burst-start strobes, the burst-advance input and all write controls are captured on the rising clock edge. The output enable and the sleep input act asynchronously on the output side. Read data comes back two rising edges after the command edge. A caller can load a fresh address on every cycle, or start a burst of up to four words and let the memory produce the following addresses itself.

Burst addresses come from a 2-bit counter that combines with the low two bits of the start address. It runs in interleaved order (XOR) or linear order (add with wrap), and the address bits above the low two stay fixed for the whole burst. Writes can target any set of byte lanes, or all lanes through a global write that overrides the lane controls. A deselect turns the output drive off one stage earlier than a read turns it on. An access still in flight when a deselect is captured never reaches the output.

Top module: `sync_burst_sram`

## Requirements
- R1: A read captured on a rising edge drives its word on `rdata`, with `rdata_vld` high, once the second rising edge after capture has passed. A new address may be given on every cycle, and the bench then sees one word per cycle in command order.
- R2: The memory is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 all hold. A start strobe with any enable inactive is a deselect and starts no access.
- R3: A start occurs when `strb_p_n` or `strb_c_n` is low. When both are low, `strb_p_n` wins and that start is a read whatever the write controls are. A start from `strb_c_n` alone follows the write controls.
- R4: During a burst the counter steps only on a cycle with `adv_n`=0 and both strobes high. On a cycle with `adv_n`=1 the same address is accessed again. `adv_n` has no effect on a start cycle.
- R5: With `order_lin`=0 (interleaved), the low two address bits of burst word k are the start offset XOR k.
- R6: With `order_lin`=1 (linear), the low two bits are (start offset + k) mod 4, wrapping inside the aligned group of four. Address bits above bit 1 stay fixed.
- R7: With `gwe_n`=1 and `bwe_n`=0, only lanes whose `lane_we_n` bit is 0 are written. Lane i is `wdata` bits [8i+7:8i]. With `bwe_n`=1 and `gwe_n`=1 nothing is written.
- R8: With `gwe_n`=0, every lane is written, regardless of `bwe_n` and `lane_we_n`.
- R9: After a deselect is captured, `rdata_vld` is low from that edge on. A read captured one edge earlier never appears.
- R10: While `oe_n`=1, `rdata_vld` is 0 and `rdata` is all zeros. This takes effect without a clock edge, and the output comes back once `oe_n` returns to 0.
- R11: While `sleep`=1, no edge changes any state or memory word, and `rdata_vld` drops to 0 at once. After wake the held read output reappears unchanged.
- R12: During and right after reset `rdata_vld` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address for a start |
| wdata | input | DATA_W | Write data, captured with the command |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| strb_p_n | input | 1 | Start strobe, higher priority, read-only start |
| strb_c_n | input | 1 | Start strobe, honours write controls |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | DATA_W/BYTE_W | Per-lane write selects, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | DATA_W | Read data, zero while not driven |
| rdata_vld | output | 1 | Output-drive flag |

## Verification
The hardest case to reach is a mixed burst: the counter must stall on a hold cycle, resume, and wrap across the group boundary in linear order, with each word checked on its own cycle. The bench builds it from a start whose offset is not zero and an advance pattern that contains a gap. It fills the group with distinct words beforehand, so an address mistake at any position shows up as a wrong word. A second hard case is the race between a pending read and a deselect. The bench closes every burst with a hold cycle followed by a deselect, and checks that the hold cycle's word never reaches the output.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // low two address bits of a burst word from its start offset and step count
  function automatic logic [1:0] burst_ofs(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       lin);
    return lin ? (start + cnt) : (start ^ cnt);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          sel_ok,
  input  logic          st_p,
  input  logic          st_c,
  input  logic          adv,
  input  logic          lin,
  input  logic [NL-1:0] wr_lanes,
  output logic [AW-1:0] s1_addr,
  output logic [DW-1:0] s1_wdata,
  output logic [NL-1:0] s1_we,
  output logic          s1_rd,
  output logic          act,
  output logic          desel_cap
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  logic          start;
  logic [AW-1:0] acc_addr;

  always_comb begin
    start     = st_p | st_c;
    desel_cap = !hold && start && !sel_ok;
    cnt_nx    = adv ? cnt_q + 2'd1 : cnt_q;
    acc_addr  = {base_q[AW-1:2], burst_ofs(base_q[1:0], cnt_nx, lin)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      s1_rd    <= 1'b0;
      s1_we    <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else if (!hold) begin
      s1_wdata <= wdata;
      if (start) begin
        if (sel_ok) begin
          act     <= 1'b1;
          base_q  <= addr;
          cnt_q   <= '0;
          s1_addr <= addr;
          s1_we   <= st_p ? '0 : wr_lanes;
          s1_rd   <= st_p || (wr_lanes == '0);
        end else begin
          act   <= 1'b0;
          s1_we <= '0;
          s1_rd <= 1'b0;
        end
      end else if (act) begin
        cnt_q   <= cnt_nx;
        s1_addr <= acc_addr;
        s1_we   <= wr_lanes;
        s1_rd   <= (wr_lanes == '0);
      end else begin
        s1_we <= '0;
        s1_rd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int NL = DW / BW
) (
  input  logic          clk,
  input  logic          en,
  input  logic [NL-1:0] we,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [BW-1:0] mem_l [DEPTH];
    logic [BW-1:0] q_l;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we[i]) mem_l[addr] <= wdata[i*BW +: BW];
        if (rd)    q_l <= mem_l[addr];
      end
    end
    assign q[i*BW +: BW] = q_l;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     strb_p_n,
  input  logic                     strb_c_n,
  input  logic                     adv_n,
  input  logic                     gwe_n,
  input  logic                     bwe_n,
  input  logic [DATA_W/BYTE_W-1:0] lane_we_n,
  input  logic                     order_lin,
  input  logic                     oe_n,
  input  logic                     sleep,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_vld
);
  localparam int LANES = DATA_W / BYTE_W;

  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] ctl_addr;
  logic [DATA_W-1:0] ctl_wdata;
  logic [LANES-1:0]  ctl_we;
  logic              ctl_rd;
  logic              ctl_act;
  logic              ctl_desel;
  logic [DATA_W-1:0] arr_q;
  logic              drv_q;

  always_comb begin
    if (!gwe_n)      wr_lanes = '1;
    else if (!bwe_n) wr_lanes = ~lane_we_n;
    else             wr_lanes = '0;
  end

  sbs_ctrl #(.AW(ADDR_W), .DW(DATA_W), .NL(LANES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .hold     (sleep),
    .addr     (addr),
    .wdata    (wdata),
    .sel_ok   (!sel_a_n && sel_b && !sel_c_n),
    .st_p     (!strb_p_n),
    .st_c     (!strb_c_n),
    .adv      (!adv_n),
    .lin      (order_lin),
    .wr_lanes (wr_lanes),
    .s1_addr  (ctl_addr),
    .s1_wdata (ctl_wdata),
    .s1_we    (ctl_we),
    .s1_rd    (ctl_rd),
    .act      (ctl_act),
    .desel_cap(ctl_desel)
  );

  sbs_array #(.AW(ADDR_W), .DW(DATA_W), .BW(BYTE_W), .NL(LANES)) u_array (
    .clk  (clk),
    .en   (!sleep),
    .we   (ctl_we),
    .rd   (ctl_rd),
    .addr (ctl_addr),
    .wdata(ctl_wdata),
    .q    (arr_q)
  );

  // drive flag: a deselect clears it at its own capture edge, a read sets it one edge later
  always_ff @(posedge clk) begin
    if (rst)             drv_q <= 1'b0;
    else if (!sleep) begin
      if (ctl_desel)     drv_q <= 1'b0;
      else               drv_q <= ctl_rd;
    end
  end

  assign rdata_vld = drv_q && !oe_n && !sleep;
  assign rdata     = rdata_vld ? arr_q : '0;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int AW = 8,
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep,
  input logic          oe_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          strb_p_n,
  input logic          strb_c_n,
  input logic          rdata_vld,
  input logic          ctl_rd,
  input logic [NL-1:0] ctl_we,
  input logic [AW-1:0] ctl_addr,
  input logic          ctl_act,
  input logic          ctl_desel,
  input logic          drv_q
);
  logic sel, start;
  assign sel   = !sel_a_n && sel_b && !sel_c_n;
  assign start = !strb_p_n || !strb_c_n;

  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!sleep && ctl_rd && !ctl_desel) |=> drv_q); // R1

  AST_SEL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!sleep && start && !sel) |=> !ctl_act); // R2

  AST_PRIO_READ: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strb_p_n && sel) |=> (ctl_we == '0)); // R3

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !start && ctl_act) |=> (ctl_addr[AW-1:2] == $past(ctl_addr[AW-1:2]))); // R6

  AST_DESEL_STOP: assert property (@(posedge clk) disable iff (rst)
    (!sleep && start && !sel) |=> !rdata_vld); // R9

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(drv_q) && $stable(ctl_addr) && $stable(ctl_act))); // R11

  always_comb begin
    if (!rst && rdata_vld) begin
      AST_OE_GATE: assert (!oe_n && !sleep); // R10
    end
  end
endmodule

bind sync_burst_sram sbs_chk #(.AW(ADDR_W), .NL(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sleep    (sleep),
  .oe_n     (oe_n),
  .sel_a_n  (sel_a_n),
  .sel_b    (sel_b),
  .sel_c_n  (sel_c_n),
  .strb_p_n (strb_p_n),
  .strb_c_n (strb_c_n),
  .rdata_vld(rdata_vld),
  .ctl_rd   (ctl_rd),
  .ctl_we   (ctl_we),
  .ctl_addr (ctl_addr),
  .ctl_act  (ctl_act),
  .ctl_desel(ctl_desel),
  .drv_q    (drv_q)
);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        strb_p_n, strb_c_n, adv_n;
  logic        gwe_n, bwe_n;
  logic [3:0]  lane_we_n;
  logic        order_lin, oe_n, sleep;
  logic [31:0] rdata;
  logic        rdata_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] model [256];

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(8), .DATA_W(32), .BYTE_W(8)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
    .order_lin(order_lin), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    strb_p_n = 1'b1; strb_c_n = 1'b1; adv_n = 1'b1;
    gwe_n = 1'b1; bwe_n = 1'b1; lane_we_n = 4'hF;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
  endtask

  task automatic drv_desel();
    idle(); strb_p_n = 1'b0; sel_b = 1'b0;
  endtask

  task automatic drv_rd(input logic [7:0] a);
    idle(); strb_p_n = 1'b0; addr = a;
  endtask

  task automatic desel_now();
    drv_desel(); tick(); idle();
  endtask

  // write through the lower-priority strobe; model follows R7/R8
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit gw, input bit bw, input logic [3:0] ln);
    idle(); strb_c_n = 1'b0; addr = a; wdata = d;
    gwe_n = !gw; bwe_n = !bw; lane_we_n = ln;
    if (gw) model[a] = d;
    else if (bw)
      for (int i = 0; i < 4; i++) if (!ln[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
    tick(); idle();
  endtask

  // expected low address bits, R5/R6
  function automatic logic [1:0] ofs(input logic [1:0] s, input logic [1:0] k, input bit lin);
    return lin ? 2'((s + k) % 4) : (s ^ k);
  endfunction

  task automatic t_reset();
    rst = 1'b1; idle(); oe_n = 1'b0; sleep = 1'b0; order_lin = 1'b0; addr = '0; wdata = '0;
    tick(); tick();
    chk(rdata_vld == 1'b0, "R12 vld during reset", 32'(rdata_vld), 0);
    rst = 1'b0; tick(); tick();
    chk(rdata_vld == 1'b0, "R12 vld after reset", 32'(rdata_vld), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 4; i++) wr(8'h10 + 8'(i), 32'hA0A0_0000 + 32'(i), 1, 0, 4'hF);
    for (int i = 0; i < 4; i++) wr(8'h24 + 8'(i), 32'hB1B1_0000 + 32'(i) * 32'h11, 1, 0, 4'hF);
    wr(8'h40, 32'h1122_3344, 1, 0, 4'hF);
    wr(8'h41, 32'h0102_0304, 1, 0, 4'hF);
    wr(8'h42, 32'h5566_7788, 1, 0, 4'hF);
    desel_now();
  endtask

  // back-to-back reads, one new address each cycle (R1), then hold + deselect (R9)
  task automatic t_read_seq(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] a3, input string tag);
    logic [7:0] a [4];
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    for (int j = 0; j < 6; j++) begin
      if (j < 4) drv_rd(a[j]);
      else if (j == 4) idle();
      else drv_desel();
      tick();
      if (j >= 1 && j <= 4) begin
        chk(rdata_vld == 1'b1, {tag, " R1 vld"}, 32'(rdata_vld), 1);
        chk(rdata == model[a[j-1]], {tag, " R1 data"}, rdata, model[a[j-1]]);
      end
      if (j == 5) chk(rdata_vld == 1'b0, {tag, " R9 off after deselect"}, 32'(rdata_vld), 0);
    end
    idle();
  endtask

  task automatic t_bytes();
    wr(8'h40, 32'hAABB_CCDD, 0, 1, 4'b1010);
    wr(8'h41, 32'hCAFE_F00D, 1, 0, 4'b1111);
    wr(8'h42, 32'hDEAD_BEEF, 0, 0, 4'b0000);
    wr(8'h10, 32'h7777_6666, 1, 1, 4'b1110);
    desel_now();
    chk(model[8'h40] == 32'h11BB_33DD, "R7 model lanes", model[8'h40], 32'h11BB_33DD);
    t_read_seq(8'h40, 8'h41, 8'h42, 8'h10, "R7 R8 lane/global");
  endtask

  // slot 0 start (adv_n low, must be ignored, R4); slots 1..4 follow advv; slot 5 hold; slot 6 deselect
  task automatic t_burst(input logic [7:0] base, input bit lin, input logic [4:1] advv, input string tag);
    logic [1:0] k;
    logic [7:0] ea;
    k = 2'd0;
    order_lin = lin;
    for (int j = 0; j < 7; j++) begin
      idle();
      if (j == 0) begin strb_p_n = 1'b0; addr = base; adv_n = 1'b0; end
      else if (j <= 4) adv_n = !advv[j];
      else if (j == 6) drv_desel();
      tick();
      if (j >= 1 && j <= 5) begin
        ea = {base[7:2], ofs(base[1:0], k, lin)};
        chk(rdata_vld == 1'b1, {tag, " vld"}, 32'(rdata_vld), 1);
        chk(rdata == model[ea], {tag, " word"}, rdata, model[ea]);
        if (j <= 4 && advv[j]) k = k + 2'd1;
      end
      if (j == 6) chk(rdata_vld == 1'b0, {tag, " R9 hold word dropped"}, 32'(rdata_vld), 0);
    end
    idle(); order_lin = 1'b0;
  endtask

  task automatic t_partial_sel();
    for (int e = 0; e < 3; e++) begin
      drv_rd(8'h40);
      if (e == 0) sel_a_n = 1'b1;
      if (e == 1) sel_b = 1'b0;
      if (e == 2) sel_c_n = 1'b1;
      tick(); idle(); tick(); tick();
      chk(rdata_vld == 1'b0, "R2 partial enable is deselect", 32'(rdata_vld), 0);
    end
  endtask

  task automatic t_priority();
    idle(); strb_p_n = 1'b0; strb_c_n = 1'b0; gwe_n = 1'b0; addr = 8'h41; wdata = 32'hBAD0_BAD0;
    tick(); idle(); tick();
    chk(rdata == model[8'h41] && rdata_vld, "R3 both strobes read", rdata, model[8'h41]);
    tick();
    chk(rdata == model[8'h41], "R3 no write on priority start", rdata, model[8'h41]);
    desel_now();
  endtask

  task automatic t_oe();
    drv_rd(8'h42); tick(); idle(); tick();
    oe_n = 1'b1; #1;
    chk(rdata_vld == 1'b0 && rdata == 32'h0, "R10 oe high off", rdata, 0);
    oe_n = 1'b0; #1;
    chk(rdata_vld == 1'b1 && rdata == model[8'h42], "R10 oe low back", rdata, model[8'h42]);
    tick(); desel_now();
  endtask

  task automatic t_sleep();
    drv_rd(8'h40); tick(); idle(); tick();
    chk(rdata == model[8'h40], "R11 pre-sleep word", rdata, model[8'h40]);
    sleep = 1'b1; strb_c_n = 1'b0; gwe_n = 1'b0; addr = 8'h40; wdata = 32'hFEED_0001; #1;
    chk(rdata_vld == 1'b0 && rdata == 32'h0, "R11 output off in sleep", rdata, 0);
    tick(); tick();
    sleep = 1'b0; idle(); #1;
    chk(rdata_vld == 1'b1 && rdata == model[8'h40], "R11 held output after wake", rdata, model[8'h40]);
    tick();
    chk(rdata == model[8'h40], "R11 no write during sleep", rdata, model[8'h40]);
    desel_now();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_read_seq(8'h13, 8'h24, 8'h11, 8'h26, "R1 new address each cycle");
    t_bytes();
    t_burst(8'h11, 1'b0, 4'b1111, "R5 R4 interleaved burst");
    t_burst(8'h25, 1'b1, 4'b1101, "R6 R4 linear burst with stall and wrap");
    t_partial_sel();
    t_priority();
    t_oe();
    t_sleep();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule